// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Fuse Configuration

This block is a watchdog built from two 8-bit down-counters in series. A prescaler makes a one-cycle enable pulse once every sixteen source ticks. The low stage counts these pulses. The high stage counts either low-stage wraps or the prescaled pulses directly, as a control bit selects. When the high stage wraps from zero, the block raises a one-cycle internal reset. Software keeps the watchdog alive by writing any value to the control register. The write reloads both stages with all ones and, if the timer was idle, starts it.

The block also decides what a stop request does. Depending on a policy bit, the request either produces a one-cycle stop grant or forces the internal reset. After reset, software may set this policy bit once only. A static configuration word, applied only when its enable input is low, can do four things:
- pin the policy bit to a fixed value;
- choose the reset value of the count-source select;
- make the timer run as soon as reset ends;
- tie the source tick to an external oscillator enable instead of the system clock.

Everything runs on one clock with a synchronous active-high reset.

Top module: `cascade_wdog`

## Requirements
- R1: When `rst` is applied with `cfg_apply_n` = 1, `rd_data` reads 8'h3F. Both stages hold 8'hFF and do not count until the first write.
- R2: `rd_data` bit 7 is the count-source select. Bit 6 is the effective stop policy. Bits 5:0 are bits 7:2 of the high-stage count.
- R3: Any cycle with `bus_wr` = 1 reloads both stages to 8'hFF and sets the timer running. `bus_wdata` bit 7 is loaded into the count-source select.
- R4: With `cfg_apply_n` = 1, the first write after reset loads `bus_wdata` bit 6 into the stop policy. Every later write leaves the policy unchanged.
- R5: While running, the low stage decrements on each prescaled pulse, wrapping 0 to 8'hFF. With select = 0 the high stage decrements on each low-stage wrap. With select = 1 it decrements on each prescaled pulse.
- R6: A high-stage wrap from 0 to 8'hFF sets `wdt_reset` high for exactly the following cycle.
- R7: `stop_req` = 1 with effective policy 0 gives `stop_grant` = 1 in the next cycle. With policy 1 it gives `wdt_reset` = 1 in the next cycle and no grant.
- R8: With `cfg_apply_n` = 0, the configuration word acts as follows. `cfg_word` bit 3 is the effective policy and writes cannot alter it. Bit 2 is the reset value of the select. Bit 1 = 1 makes the timer run right after reset.
- R9: With `cfg_apply_n` = 0 and `cfg_word` bit 0 = 1, the prescaler advances only in cycles where `osc_tick` = 1. Otherwise it advances every cycle, giving a pulse every 16 cycles.
- R10: With `cfg_apply_n` = 1, `cfg_word` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_apply_n | input | 1 | 0 applies the configuration word |
| cfg_word | input | 4 | {policy, select reset value, auto-run, oscillator-only source} |
| osc_tick | input | 1 | One-cycle enable marking an on-chip oscillator tick |
| bus_wr | input | 1 | Control register write strobe |
| bus_wdata | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| stop_req | input | 1 | Stop instruction request |
| stop_grant | output | 1 | One-cycle stop mode grant |
| wdt_reset | output | 1 | One-cycle internal reset request |

## Verification
The assertions assume that `cfg_word` and `cfg_apply_n` change only while `rst` is high, because they act as static fuses. The stimulus changes them only inside reset pulses. Random traffic also keeps writes and stop requests sparse, so that the stages get deep enough for wraps to happen. The bench treats `osc_tick` as a free input and drives it in any pattern, including long idle stretches.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CNT_W = 8;
    localparam int DIV_W = 4;
    localparam int SEL_BIT = CNT_W - 1;
    localparam int POL_BIT = CNT_W - 2;

    typedef struct packed {
        logic pol_fix;
        logic sel_init;
        logic auto_run;
        logic osc_only;
    } wdg_cfg_t;

    typedef struct packed {
        logic             sel;
        logic             pol;
        logic [CNT_W-3:0] hi_top;
    } wdg_status_t;

    function automatic wdg_status_t make_status(logic sel, logic pol, logic [CNT_W-1:0] hi);
        wdg_status_t s;
        s.sel    = sel;
        s.pol    = pol;
        s.hi_top = hi[CNT_W-1:2];
        return s;
    endfunction
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int DIV_W = wdg_pkg::DIV_W
) (
    input  logic clk,
    input  logic rst,
    input  logic src_tick,
    output logic tick
);
    logic [DIV_W-1:0] div_q;

    assign tick = src_tick && (div_q == {DIV_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)           div_q <= '0;
        else if (src_tick) div_q <= div_q + 1'b1;
    end

    // A prescaled pulse needs a full divider period before the next one.
    p_tick_gap_r9: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage #(
    parameter int W = wdg_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = en && !load && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || load) cnt <= '1;
        else if (en)     cnt <= cnt - 1'b1;
    end

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == {W{1'b1}}));
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(cnt));
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_on,
    input  wdg_cfg_t         cfg,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic             sel,
    output logic             pol_eff,
    output logic             run
);
    logic b6_q;
    logic lock_q;

    assign pol_eff = cfg_on ? cfg.pol_fix : b6_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel    <= cfg_on && cfg.sel_init;
            run    <= cfg_on && cfg.auto_run;
            b6_q   <= 1'b0;
            lock_q <= 1'b0;
        end else if (wr) begin
            sel    <= wdata[SEL_BIT];
            run    <= 1'b1;
            lock_q <= 1'b1;
            if (!lock_q) b6_q <= wdata[POL_BIT];
        end
    end

    p_once_r4: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(b6_q));
    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        wr |=> run);
endmodule

// File: rtl/cascade_wdog.sv
module cascade_wdog
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_apply_n,
    input  logic [3:0]       cfg_word,
    input  logic             osc_tick,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] rd_data,
    input  logic             stop_req,
    output logic             stop_grant,
    output logic             wdt_reset
);
    wdg_cfg_t         cfg;
    logic             cfg_on;
    logic             src_tick, pre_tick;
    logic             sel, pol_eff, run;
    logic             lo_en, hi_en, lo_wrap, hi_wrap;
    logic [CNT_W-1:0] lo_cnt, hi_cnt;
    wdg_status_t      status;

    assign cfg      = wdg_cfg_t'(cfg_word);
    assign cfg_on   = !cfg_apply_n;
    assign src_tick = (cfg_on && cfg.osc_only) ? osc_tick : 1'b1;

    wdg_prescaler #(.DIV_W(DIV_W)) i_pre (
        .clk(clk), .rst(rst), .src_tick(src_tick), .tick(pre_tick));

    wdg_ctrl i_ctrl (
        .clk(clk), .rst(rst), .cfg_on(cfg_on), .cfg(cfg), .wr(bus_wr),
        .wdata(bus_wdata), .sel(sel), .pol_eff(pol_eff), .run(run));

    assign lo_en = run && pre_tick;
    assign hi_en = run && (sel ? pre_tick : lo_wrap);

    wdg_stage #(.W(CNT_W)) i_lo (
        .clk(clk), .rst(rst), .load(bus_wr), .en(lo_en), .cnt(lo_cnt), .wrap(lo_wrap));
    wdg_stage #(.W(CNT_W)) i_hi (
        .clk(clk), .rst(rst), .load(bus_wr), .en(hi_en), .cnt(hi_cnt), .wrap(hi_wrap));

    assign status  = make_status(sel, pol_eff, hi_cnt);
    assign rd_data = status;

    wire unused_lo = ^lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdt_reset  <= 1'b0;
            stop_grant <= 1'b0;
        end else begin
            wdt_reset  <= hi_wrap || (stop_req && pol_eff);
            stop_grant <= stop_req && !pol_eff;
        end
    end

    p_wrap_reset_r6: assert property (@(posedge clk) disable iff (rst)
        hi_wrap |=> wdt_reset);
    p_grant_r7: assert property (@(posedge clk) disable iff (rst)
        stop_grant |-> ($past(stop_req) && !$past(pol_eff)));
    p_stop_reset_r7: assert property (@(posedge clk) disable iff (rst)
        (stop_req && pol_eff) |=> (wdt_reset && !stop_grant));
endmodule

// File: tb/test_cascade_wdog.sv
module test_cascade_wdog;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_apply_n = 1'b1;
    logic [3:0] cfg_word = 4'h0;
    logic       osc_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       stop_req = 1'b0;
    logic [7:0] rd_data;
    logic       stop_grant, wdt_reset;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    cascade_wdog i_cascade_wdog (
        .clk(clk), .rst(rst), .cfg_apply_n(cfg_apply_n), .cfg_word(cfg_word),
        .osc_tick(osc_tick), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .stop_req(stop_req), .stop_grant(stop_grant),
        .wdt_reset(wdt_reset));

    // Behavioural model built from the requirements
    int   m_div, m_lo, m_hi;
    logic m_run, m_sel, m_b6, m_lock, e_rst, e_grant;

    function automatic logic eff_pol(logic b6);
        return (!cfg_apply_n) ? cfg_word[3] : b6;
    endfunction

    always @(posedge clk) begin
        logic cfgon, pol, srct, pt, lw, hu;
        cfgon = !cfg_apply_n;
        if (rst) begin
            m_div <= 0; m_lo <= 255; m_hi <= 255;
            m_run <= cfgon && cfg_word[1];
            m_sel <= cfgon && cfg_word[2];
            m_b6 <= 1'b0; m_lock <= 1'b0; e_rst <= 1'b0; e_grant <= 1'b0;
        end else begin
            pol  = eff_pol(m_b6);
            srct = (cfgon && cfg_word[0]) ? osc_tick : 1'b1;
            pt   = srct && (m_div == 15);
            hu   = 1'b0;
            if (srct) m_div <= (m_div + 1) % 16;
            if (bus_wr) begin
                m_lo <= 255; m_hi <= 255; m_run <= 1'b1; m_sel <= bus_wdata[7];
                if (!m_lock) m_b6 <= bus_wdata[6];
                m_lock <= 1'b1;
            end else if (m_run && pt) begin
                lw = (m_lo == 0);
                m_lo <= lw ? 255 : m_lo - 1;
                if (m_sel || lw) begin
                    hu = (m_hi == 0);
                    m_hi <= hu ? 255 : m_hi - 1;
                end
            end
            e_rst   <= hu || (stop_req && pol);
            e_grant <= stop_req && !pol;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Continuous comparison at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 rd_data", rd_data, {m_sel, eff_pol(m_b6), m_hi[7:2]});
            chk("R6 wdt_reset", {7'd0, wdt_reset}, {7'd0, e_rst});
            chk("R7 stop_grant", {7'd0, stop_grant}, {7'd0, e_grant});
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(logic apply_n, logic [3:0] w);
        @(negedge clk);
        rst = 1'b1; cfg_apply_n = apply_n; cfg_word = w;
        cyc(2);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic stop_pulse();
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    // Waits for a wdt_reset pulse; returns cycles waited or -1
    task automatic wait_rst(int lim, output int n);
        n = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (wdt_reset) begin n = i; break; end
        end
    endtask

    bit done = 0;

    initial begin
        int n;
        logic [7:0] r0;
        int unsigned seed;
        seed = $urandom(32'd4242);

        // R1 / R10: reset state, configuration ignored when not applied
        do_reset(1'b1, 4'hF);
        chk("R1 reset read", rd_data, 8'h3F);
        chk("R10 cfg ignored", rd_data, 8'h3F);
        cyc(200);
        chk("R1 idle no count", rd_data, 8'h3F);
        chk("R1 no reset pulse", {7'd0, wdt_reset}, 8'd0);

        // R4: first write sets policy, later write cannot clear it
        wr(8'h40);
        chk("R4 first write", {7'd0, rd_data[6]}, 8'd1);
        wr(8'h80);
        chk("R4 second write ignored", {7'd0, rd_data[6]}, 8'd1);
        chk("R3 select loaded", {7'd0, rd_data[7]}, 8'd1);

        // R7: policy 1 -> stop gives reset, no grant
        stop_pulse();
        chk("R7 stop forces reset", {6'd0, wdt_reset, stop_grant}, 8'b10);

        // R5/R6: select=1, high stage wraps after 256 prescaled pulses
        wr(8'h80);
        wait_rst(4200, n);
        chk("R6 wrap seen", {7'd0, n >= 4080 && n <= 4112}, 8'd1);
        @(negedge clk);
        chk("R6 single cycle", {7'd0, wdt_reset}, 8'd0);

        // R5: select=0 cascade, policy 0 with grant
        do_reset(1'b1, 4'h0);
        wr(8'h00);
        chk("R3 reload", rd_data, 8'h3F);
        stop_pulse();
        chk("R7 grant", {6'd0, wdt_reset, stop_grant}, 8'b01);
        cyc(4 * 4096 + 40);
        chk("R5 cascade count", {2'd0, rd_data[5:0]}, 8'h3E);
        r0 = rd_data;
        wr(8'h00);
        chk("R3 write restarts", rd_data, 8'h3F);

        // R8: applied configuration
        do_reset(1'b0, 4'b1110);
        chk("R8 cfg reset value", rd_data, 8'hFF);
        wait_rst(4200, n);
        chk("R8 auto run", {7'd0, n >= 0}, 8'd1);
        wr(8'h00);
        chk("R8 policy forced", rd_data, 8'h7F);
        stop_pulse();
        chk("R8 forced policy reset", {6'd0, wdt_reset, stop_grant}, 8'b10);

        // R9: oscillator-only source
        do_reset(1'b0, 4'b0001);
        wr(8'h80);
        osc_tick = 1'b0;
        cyc(300);
        chk("R9 no osc no count", rd_data, 8'hBF);
        osc_tick = 1'b1;
        cyc(16 * 8 + 20);
        osc_tick = 1'b0;
        chk("R9 osc counts", {7'd0, rd_data[5:0] != 6'h3F}, 8'd1);

        // Random phase across configurations
        for (int k = 0; k < 6; k++) begin
            do_reset(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
            for (int c = 0; c < 2500; c++) begin
                osc_tick  = 1'($urandom_range(0, 1));
                bus_wr    = ($urandom_range(0, 399) == 0);
                bus_wdata = 8'($urandom_range(0, 255));
                stop_req  = ($urandom_range(0, 149) == 0);
                @(negedge clk);
            end
            bus_wr = 1'b0; stop_req = 1'b0;
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule